// File: doc/BRIEF.md
# Beat Period Collector

This block measures how many reference-counter ticks separate two beat-detector events. Each event arrives as a one-cycle ready strobe together with a W-bit timestamp. Events are taken in disjoint pairs. The first event of a pair is held as the start stamp. The second event closes the pair, and the block forms the span between the two stamps. It also forms a signed error equal to a nominal span N minus the measured span. A helper frequency-lock loop uses that error to steer its oscillator.

A consumer requests a result by pulsing an arm input once per update interval. A closed pair is reported only when the request was already pending. The report is a one-cycle valid pulse with the span and the error, and it withdraws the request. A pair that closes while no request is pending is dropped, but it still counts as a consumed pair. Outside a report cycle, all outputs read zero.

Top module: `beat_period_collector`

## Requirements
- R1: After a synchronous active-high reset, the block waits for a first stamp, has no pending request and holds a zero start stamp. Valid, span and error read 0 until a new pair closes.
- R2: A ready strobe while the block waits for a first stamp latches the stamp as the start. No output is produced for that strobe.
- R3: The ready strobe that closes a pair yields span = new stamp minus start stamp. If a request is pending, valid is 1 and the span is shown in the cycle after the clock edge that samples the strobe.
- R4: The subtraction is taken modulo 2^W, so a counter wrap between the two stamps still gives the correct positive span (start 250, end 5, W=8 gives 11).
- R5: Pairs are disjoint. After a pair closes, the block waits for a fresh first stamp, so every measurement needs two new strobes.
- R6: The error is the two's-complement value N minus span, ERR_W bits wide. It saturates to 2^(ERR_W-1)-1 or -2^(ERR_W-1) instead of wrapping.
- R7: In every cycle without a report, valid, span and error are all 0.
- R8: A pulse on arm sets the pending request from the next cycle onward. A pair that closes without a pending request is dropped: there is no valid pulse and the request state is unchanged.
- R9: Reporting a result clears the pending request. If arm is high in the same cycle as the closing strobe, the request stays pending.
- R10: Valid is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tag_ready | input | 1 | One-cycle strobe: a beat stamp is present |
| tag | input | TAG_W | Beat timestamp from the free-running counter |
| arm | input | 1 | Request for one fresh result |
| valid | output | 1 | One-cycle result pulse |
| period | output | TAG_W | Measured beat span, zero when not valid |
| period_err | output | ERR_W | Signed N minus span, saturated, zero when not valid |

## Verification
A table of pairs covers these cases: a span exactly at N (error zero), a span above N (negative error), a wrapped pair, a span of zero, and spans on each side of the positive saturation limit. Together they separate a correct modulo subtraction and clamp from a wrapped or unclamped one. Back-to-back table pairs show that every measurement starts from a fresh start stamp rather than a running difference. Directed sequences cover four cases. An unarmed pair shows that a dropped result leaves the request untouched. Arm raised on the closing strobe shows the request is set from the next cycle. A second pair after a report shows that the report clears the request. A reset between the two stamps of a pair shows the half-finished pair is discarded.

// File: rtl/beatp_pkg.sv
package beatp_pkg;
  typedef enum logic {
    BP_WAIT_START = 1'b0,
    BP_WAIT_END   = 1'b1
  } bp_state_e;
endpackage

// File: rtl/beatp_pair_fsm.sv
module beatp_pair_fsm
  import beatp_pkg::*;
#(
  parameter int TAG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tag_ready,
  input  logic [TAG_W-1:0] tag,
  output logic             pair_done,
  output logic [TAG_W-1:0] pair_span
);
  bp_state_e        state_q;
  logic [TAG_W-1:0] start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BP_WAIT_START;
      start_q <= '0;
    end else if (tag_ready) begin
      if (state_q == BP_WAIT_START) begin
        start_q <= tag;
        state_q <= BP_WAIT_END;
      end else begin
        state_q <= BP_WAIT_START;
      end
    end
  end

  // modulo 2^TAG_W difference, so a counter wrap still yields a positive span
  assign pair_done = tag_ready && (state_q == BP_WAIT_END);
  assign pair_span = tag - start_q;
endmodule

// File: rtl/beatp_err_sat.sv
module beatp_err_sat #(
  parameter int TAG_W = 16,
  parameter int ERR_W = 17,
  parameter int NOM   = 1024
) (
  input  logic [TAG_W-1:0] span,
  output logic [ERR_W-1:0] err
);
  localparam int CW = ((TAG_W > 31) ? TAG_W : 31) + 2;

  logic signed [CW-1:0] nom_s, span_s, diff_s, max_s, min_s;

  always_comb begin
    nom_s  = CW'(NOM);
    span_s = CW'(span);
    diff_s = nom_s - span_s;
    max_s  = (CW'(1) <<< (ERR_W - 1)) - CW'(1);
    min_s  = -(CW'(1) <<< (ERR_W - 1));
    if (diff_s > max_s)      err = max_s[ERR_W-1:0];
    else if (diff_s < min_s) err = min_s[ERR_W-1:0];
    else                     err = diff_s[ERR_W-1:0];
  end
endmodule

// File: rtl/beatp_arm_gate.sv
module beatp_arm_gate (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic pair_done,
  output logic deliver,
  output logic armed_q
);
  assign deliver = pair_done && armed_q;

  // a new request wins over the clear caused by a delivery in the same cycle
  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= arm || (armed_q && !deliver);
  end
endmodule

// File: rtl/beat_period_collector.sv
module beat_period_collector #(
  parameter int TAG_W = 16,
  parameter int ERR_W = TAG_W + 1,
  parameter int NOM   = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tag_ready,
  input  logic [TAG_W-1:0] tag,
  input  logic             arm,
  output logic             valid,
  output logic [TAG_W-1:0] period,
  output logic [ERR_W-1:0] period_err
);
  logic             pair_done;
  logic [TAG_W-1:0] pair_span;
  logic [ERR_W-1:0] span_err;
  logic             deliver;
  logic             armed_q;

  beatp_pair_fsm #(.TAG_W(TAG_W)) u_pair (
    .clk(clk), .rst(rst), .tag_ready(tag_ready), .tag(tag),
    .pair_done(pair_done), .pair_span(pair_span)
  );

  beatp_err_sat #(.TAG_W(TAG_W), .ERR_W(ERR_W), .NOM(NOM)) u_err (
    .span(pair_span), .err(span_err)
  );

  beatp_arm_gate u_arm (
    .clk(clk), .rst(rst), .arm(arm), .pair_done(pair_done),
    .deliver(deliver), .armed_q(armed_q)
  );

  always_ff @(posedge clk) begin
    if (rst || !deliver) begin
      valid      <= 1'b0;
      period     <= '0;
      period_err <= '0;
    end else begin
      valid      <= 1'b1;
      period     <= pair_span;
      period_err <= span_err;
    end
  end
endmodule

// File: rtl/beatp_checker.sv
module beatp_checker #(
  parameter int TAG_W = 16,
  parameter int ERR_W = 17,
  parameter int NOM   = 1024
) (
  input logic             clk,
  input logic             rst,
  input logic             tag_ready,
  input logic             arm,
  input logic             armed_q,
  input logic             valid,
  input logic [TAG_W-1:0] period,
  input logic [ERR_W-1:0] period_err
);
  AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (period == '0 && period_err == '0)); // R7

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R10

  AST_CAUSED_BY_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> ($past(tag_ready) && $past(armed_q))); // R3

  AST_REQUEST_CLEARED: assert property (@(posedge clk) disable iff (rst)
    valid |-> (!armed_q || $past(arm))); // R9

  AST_ERR_ZERO_AT_NOM: assert property (@(posedge clk) disable iff (rst)
    (valid && period == TAG_W'(NOM)) |-> (period_err == '0)); // R6

  AST_ERR_SIGN: assert property (@(posedge clk) disable iff (rst)
    (valid && int'(period) > NOM) |-> period_err[ERR_W-1]); // R6
endmodule

bind beat_period_collector beatp_checker #(.TAG_W(TAG_W), .ERR_W(ERR_W), .NOM(NOM)) u_chk (
  .clk(clk), .rst(rst), .tag_ready(tag_ready), .arm(arm), .armed_q(armed_q),
  .valid(valid), .period(period), .period_err(period_err)
);

// File: tb/tb_beat_period_collector.sv
module tb_beat_period_collector;
  localparam int TW  = 8;
  localparam int EW  = 8;
  localparam int NOM = 200;
  localparam int NV  = 8;

  // stimulus: start stamp, end stamp, armed; expected: span, error (saturated)
  localparam int VT1  [NV] = '{10, 250,   0, 100,  7,   0,   0, 100};
  localparam int VT2  [NV] = '{210,  5, 255, 100, 57,  72,  73,  50};
  localparam int VARM [NV] = '{1,    1,   1,   1,  0,   1,   1,   1};
  localparam int VEP  [NV] = '{200, 11, 255,   0,  0,  72,  73, 206};
  localparam int VEE  [NV] = '{0,  127, -55, 127,  0, 127, 127,  -6};
  localparam string VRQ [NV] = '{"R3", "R4", "R6", "R6", "R8", "R6", "R6", "R5"};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tag_ready = 1'b0;
  logic [TW-1:0] tag = '0;
  logic          arm = 1'b0;
  logic          valid;
  logic [TW-1:0] period;
  logic [EW-1:0] period_err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  beat_period_collector #(.TAG_W(TW), .ERR_W(EW), .NOM(NOM)) dut (
    .clk(clk), .rst(rst), .tag_ready(tag_ready), .tag(tag), .arm(arm),
    .valid(valid), .period(period), .period_err(period_err)
  );

  task automatic chk(input string rq, input int ev, input int ep, input int ee);
    checks++;
    if (int'(valid) != ev || int'(period) != ep || int'($signed(period_err)) != ee) begin
      errors++;
      $display("FAIL %s: actual valid=%0d period=%0d err=%0d expected valid=%0d period=%0d err=%0d",
               rq, valid, period, $signed(period_err), ev, ep, ee);
    end
  endtask

  task automatic strobe(input int t, input logic a);
    @(negedge clk);
    tag_ready = 1'b1; tag = TW'(t); arm = a;
    @(negedge clk);
    tag_ready = 1'b0; arm = 1'b0;
  endtask

  task automatic arm_pulse();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=completed");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset state", 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      if (VARM[i] != 0) arm_pulse();
      strobe(VT1[i], 1'b0);
      chk("R2 first stamp silent", 0, 0, 0);
      strobe(VT2[i], 1'b0);
      if (VARM[i] != 0) chk(VRQ[i], 1, VEP[i], VEE[i]);
      else              chk("R8 unarmed pair dropped", 0, 0, 0);
      @(negedge clk);
      chk("R10 R7 pulse ends", 0, 0, 0);
    end

    // R9: delivery clears the request
    arm_pulse();
    strobe(10, 1'b0); strobe(20, 1'b0);
    chk("R9 armed delivery", 1, 10, 127);
    strobe(30, 1'b0); strobe(40, 1'b0);
    chk("R9 request cleared", 0, 0, 0);

    // R8: arm on the closing strobe is too late, but it stays pending
    strobe(1, 1'b0); strobe(9, 1'b1);
    chk("R8 late arm not used", 0, 0, 0);
    strobe(2, 1'b0); strobe(12, 1'b0);
    chk("R8 request kept after drop", 1, 10, 127);

    // R9: arm together with a delivering strobe keeps the request
    arm_pulse();
    strobe(0, 1'b0); strobe(150, 1'b1);
    chk("R9 deliver with arm", 1, 150, 50);
    strobe(3, 1'b0); strobe(5, 1'b0);
    chk("R9 rearmed delivery", 1, 2, 127);
    strobe(6, 1'b0); strobe(8, 1'b0);
    chk("R9 cleared again", 0, 0, 0);

    // R1: reset in mid-pair discards the start stamp and the request
    arm_pulse();
    strobe(40, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 outputs after reset", 0, 0, 0);
    strobe(60, 1'b0); strobe(70, 1'b0);
    chk("R1 request cleared", 0, 0, 0);
    arm_pulse();
    strobe(60, 1'b0);
    chk("R2 new start after reset", 0, 0, 0);
    strobe(250, 1'b0);
    chk("R3 span after reset", 1, 190, 10);

    finish_run();
  end
endmodule